// File: doc/BRIEF.md
# Floating-Point Compare Condition-Code Unit

This block compares two extended-precision floating-point operands and reports the outcome as a three-bit condition code. Each operand is 80 bits wide: a sign bit, a 15-bit biased exponent and a 64-bit significand whose top bit is an explicit integer bit. A mode input selects the compare flavour. In the unordered flavour a quiet NaN is an ordinary "unordered" result. In the ordered flavour any NaN is an invalid operation.

A request is a one-cycle strobe with both operands and control inputs. One cycle later the block presents the condition code, the stack-status bit, the invalid-operand, denormal and stack-fault exception bits, and the number of stack pops that a separate register-stack unit must perform. The condition code updates on an invalid-operand exception only when that exception is masked. Otherwise it keeps the value it had before the request. Stack underflow is detected outside the block and comes in as a flag.

Top module: `fcmp_cc_unit`

## Requirements
- R1: After reset, `rsp_valid`, `cc`, `c1`, all three exception bits and `pop_cnt` are 0.
- R2: `rsp_valid` is 1 in the cycle after each cycle with `req_valid` high, and 0 otherwise, so one request gives exactly one response pulse.
- R3: For ordered operands, `cc` = {C3,C2,C0} is 3'b000 when A > B, 3'b001 when A < B and 3'b100 when A = B. Signs are respected, +0 equals -0, and two infinities of the same sign are equal.
- R4: With `unordered_mode`=1, a quiet NaN in either operand gives `cc`=3'b111 and `exc_invalid`=0. A quiet NaN has exponent all ones, bit 63 = 1 and bit 62 = 1.
- R5: With `unordered_mode`=1, a signaling NaN or an unsupported encoding in either operand sets `exc_invalid`=1. `cc` becomes 3'b111 if `inv_mask`=1 and otherwise keeps its previous value. A signaling NaN has exponent all ones, bit 63 = 1, bit 62 = 0 and bits 61:0 nonzero.
- R6: With `unordered_mode`=0, any NaN or unsupported encoding sets `exc_invalid`=1, with the same masking rule for `cc` as R5.
- R7: `exc_denormal` is 1 when either operand is denormal, which means exponent 0 and significand nonzero.
- R8: When `stk_underflow`=1, the response has `exc_stack`=1, `c1`=0, `exc_invalid`=1 and `exc_denormal`=0. `cc` follows the masking rule of R5. A response without underflow has `c1`=1.
- R9: `pop_cnt` carries `pop_req` (0, 1 or 2) with the response, and a request of 3 is limited to 2. `pop_cnt` and the exception bits are 0 in cycles without a response.
- R10: An operand is unsupported when its exponent is nonzero and bit 63 is 0. This covers unnormals, and pseudo-NaNs or pseudo-infinities (exponent all ones). With exponent all ones and bit 63 = 1, significand bits 62:0 of zero mean infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Compare request strobe |
| unordered_mode | input | 1 | 1 = unordered compare, 0 = ordered compare |
| inv_mask | input | 1 | Invalid-operation exception mask |
| stk_underflow | input | 1 | Operand stack underflow detected |
| pop_req | input | 2 | Pops requested by the instruction variant |
| op_a | input | 80 | First operand |
| op_b | input | 80 | Second operand |
| rsp_valid | output | 1 | Response strobe |
| cc | output | 3 | Condition code {C3,C2,C0} |
| c1 | output | 1 | Condition bit C1 |
| exc_invalid | output | 1 | Invalid-operand exception |
| exc_denormal | output | 1 | Denormal-operand exception |
| exc_stack | output | 1 | Stack-fault exception |
| pop_cnt | output | 2 | Pops for the stack unit |

## Verification
The bench builds the block at its default 15-bit exponent and 64-bit significand with the split comparator (CMP_SPLIT=1). That variant decides on the exponent first and falls back to the significand. With it, equal-exponent ties, values that differ only in the low significand bit, and sign and zero corner cases all reach the comparator. The default widths also give the explicit integer bit and the quiet bit at their true positions. The bench can therefore build unnormals, pseudo-infinities, and quiet and signaling NaNs that land in the right class.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
   typedef enum logic [2:0] {
      CLS_ZERO   = 3'd0,
      CLS_DENORM = 3'd1,
      CLS_NORMAL = 3'd2,
      CLS_INF    = 3'd3,
      CLS_QNAN   = 3'd4,
      CLS_SNAN   = 3'd5,
      CLS_UNSUP  = 3'd6
   } fcls_e;

   localparam logic [2:0] CC_GT = 3'b000;
   localparam logic [2:0] CC_LT = 3'b001;
   localparam logic [2:0] CC_EQ = 3'b100;
   localparam logic [2:0] CC_UN = 3'b111;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
   import fcmp_pkg::*;
#(
   parameter int EXP_W = 15,
   parameter int SIG_W = 64,
   localparam int TOT_W = 1 + EXP_W + SIG_W
) (
   input  logic [TOT_W-1:0] op,
   output fcls_e            cls,
   output logic             sign
);
   logic [EXP_W-1:0] exp_f;
   logic [SIG_W-1:0] sig_f;
   logic             int_bit;
   logic             quiet_bit;
   logic             frac_nz;

   assign sign      = op[TOT_W-1];
   assign exp_f     = op[SIG_W +: EXP_W];
   assign sig_f     = op[SIG_W-1:0];
   assign int_bit   = sig_f[SIG_W-1];
   assign quiet_bit = sig_f[SIG_W-2];
   assign frac_nz   = |sig_f[SIG_W-2:0];

   always_comb begin
      if (exp_f == '0) begin
         cls = (sig_f == '0) ? CLS_ZERO : CLS_DENORM;
      end else if (!int_bit) begin
         cls = CLS_UNSUP;
      end else if (&exp_f) begin
         if (!frac_nz)      cls = CLS_INF;
         else if (quiet_bit) cls = CLS_QNAN;
         else                cls = CLS_SNAN;
      end else begin
         cls = CLS_NORMAL;
      end
   end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
   import fcmp_pkg::*;
#(
   parameter int EXP_W     = 15,
   parameter int SIG_W     = 64,
   parameter bit CMP_SPLIT = 1'b1,
   localparam int TOT_W = 1 + EXP_W + SIG_W
) (
   input  logic [TOT_W-1:0] op_a,
   input  logic [TOT_W-1:0] op_b,
   input  logic             a_zero,
   input  logic             b_zero,
   output logic [2:0]       rel
);
   logic mag_gt;
   logic mag_eq;
   logic sa;
   logic sb;

   assign sa = op_a[TOT_W-1];
   assign sb = op_b[TOT_W-1];

   generate
      if (CMP_SPLIT) begin : g_split
         logic exp_gt, exp_eq, sig_gt, sig_eq;
         assign exp_gt = op_a[SIG_W +: EXP_W] >  op_b[SIG_W +: EXP_W];
         assign exp_eq = op_a[SIG_W +: EXP_W] == op_b[SIG_W +: EXP_W];
         assign sig_gt = op_a[SIG_W-1:0] >  op_b[SIG_W-1:0];
         assign sig_eq = op_a[SIG_W-1:0] == op_b[SIG_W-1:0];
         assign mag_gt = exp_gt | (exp_eq & sig_gt);
         assign mag_eq = exp_eq & sig_eq;
      end else begin : g_flat
         assign mag_gt = op_a[TOT_W-2:0] >  op_b[TOT_W-2:0];
         assign mag_eq = op_a[TOT_W-2:0] == op_b[TOT_W-2:0];
      end
   endgenerate

   always_comb begin
      if (a_zero && b_zero) begin
         rel = CC_EQ;
      end else if (sa != sb) begin
         rel = sa ? CC_LT : CC_GT;
      end else if (mag_eq) begin
         rel = CC_EQ;
      end else if (mag_gt ^ sa) begin
         rel = CC_GT;
      end else begin
         rel = CC_LT;
      end
   end
endmodule

// File: rtl/fcmp_cc_unit.sv
module fcmp_cc_unit
   import fcmp_pkg::*;
#(
   parameter int EXP_W     = 15,
   parameter int SIG_W     = 64,
   parameter bit CMP_SPLIT = 1'b1,
   localparam int TOT_W = 1 + EXP_W + SIG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             unordered_mode,
   input  logic             inv_mask,
   input  logic             stk_underflow,
   input  logic [1:0]       pop_req,
   input  logic [TOT_W-1:0] op_a,
   input  logic [TOT_W-1:0] op_b,
   output logic             rsp_valid,
   output logic [2:0]       cc,
   output logic             c1,
   output logic             exc_invalid,
   output logic             exc_denormal,
   output logic             exc_stack,
   output logic [1:0]       pop_cnt
);
   generate
      if (EXP_W < 2) begin : g_bad_exp
         $error("fcmp_cc_unit: EXP_W must be at least 2");
      end
      if (SIG_W < 3) begin : g_bad_sig
         $error("fcmp_cc_unit: SIG_W must be at least 3");
      end
   endgenerate

   logic [TOT_W-1:0] ops [2];
   fcls_e            cls [2];
   logic             sgn [2];

   assign ops[0] = op_a;
   assign ops[1] = op_b;

   generate
      for (genvar gi = 0; gi < 2; gi++) begin : g_cls
         fcmp_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls (
            .op   (ops[gi]),
            .cls  (cls[gi]),
            .sign (sgn[gi])
         );
      end
   endgenerate

   logic [2:0] rel;

   fcmp_order #(.EXP_W(EXP_W), .SIG_W(SIG_W), .CMP_SPLIT(CMP_SPLIT)) u_order (
      .op_a   (op_a),
      .op_b   (op_b),
      .a_zero (cls[0] == CLS_ZERO),
      .b_zero (cls[1] == CLS_ZERO),
      .rel    (rel)
   );

   logic       any_qnan, any_snan, any_unsup, any_den, unord, inv_nxt;
   logic [2:0] cc_nxt;
   logic [1:0] pop_nxt;

   always_comb begin
      any_qnan  = (cls[0] == CLS_QNAN)   | (cls[1] == CLS_QNAN);
      any_snan  = (cls[0] == CLS_SNAN)   | (cls[1] == CLS_SNAN);
      any_unsup = (cls[0] == CLS_UNSUP)  | (cls[1] == CLS_UNSUP);
      any_den   = (cls[0] == CLS_DENORM) | (cls[1] == CLS_DENORM);
      unord     = any_qnan | any_snan | any_unsup;
      inv_nxt   = stk_underflow |
                  (unordered_mode ? (any_snan | any_unsup) : unord);
      if (stk_underflow) begin
         cc_nxt = inv_mask ? CC_UN : cc;
      end else if (unord) begin
         cc_nxt = (inv_nxt && !inv_mask) ? cc : CC_UN;
      end else begin
         cc_nxt = rel;
      end
      pop_nxt = (pop_req > 2'd2) ? 2'd2 : pop_req;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         cc           <= CC_GT;
         c1           <= 1'b0;
         exc_invalid  <= 1'b0;
         exc_denormal <= 1'b0;
         exc_stack    <= 1'b0;
         pop_cnt      <= 2'd0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            cc           <= cc_nxt;
            c1           <= !stk_underflow;
            exc_invalid  <= inv_nxt;
            exc_denormal <= any_den && !stk_underflow;
            exc_stack    <= stk_underflow;
            pop_cnt      <= pop_nxt;
         end else begin
            exc_invalid  <= 1'b0;
            exc_denormal <= 1'b0;
            exc_stack    <= 1'b0;
            pop_cnt      <= 2'd0;
         end
      end
   end

   // R2: one response pulse per request
   a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R4: a quiet NaN alone in unordered mode raises nothing
   a_r4_qnan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && unordered_mode && !stk_underflow && any_qnan && !any_snan && !any_unsup)
      |=> (!exc_invalid && cc == CC_UN));
   // R5, R6: unmasked invalid keeps the condition code
   a_r5_cc_held_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && exc_invalid && !$past(inv_mask)) |-> $stable(cc));
   // R8: C1 low on underflow
   a_r8_c1_low_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && exc_stack) |-> (!c1 && exc_invalid && !exc_denormal));
   // R9: pop count bounded and quiet when idle
   a_r9_pop_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      pop_cnt != 2'd3);
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (pop_cnt == 2'd0 && !exc_invalid && !exc_denormal && !exc_stack));
endmodule

// File: tb/fcmp_cc_unit_tb.sv
module fcmp_cc_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        unordered_mode = 1'b0;
   logic        inv_mask = 1'b0;
   logic        stk_underflow = 1'b0;
   logic [1:0]  pop_req = 2'd0;
   logic [79:0] op_a = '0;
   logic [79:0] op_b = '0;
   logic        rsp_valid, c1, exc_invalid, exc_denormal, exc_stack;
   logic [2:0]  cc;
   logic [1:0]  pop_cnt;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   fcmp_cc_unit #(.EXP_W(15), .SIG_W(64), .CMP_SPLIT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .unordered_mode(unordered_mode), .inv_mask(inv_mask),
      .stk_underflow(stk_underflow), .pop_req(pop_req),
      .op_a(op_a), .op_b(op_b), .rsp_valid(rsp_valid), .cc(cc), .c1(c1),
      .exc_invalid(exc_invalid), .exc_denormal(exc_denormal),
      .exc_stack(exc_stack), .pop_cnt(pop_cnt)
   );

   function automatic logic [79:0] mk(input logic s, input logic [14:0] e, input logic [63:0] m);
      return {s, e, m};
   endfunction

   localparam logic [63:0] INTB = 64'h8000_0000_0000_0000;
   logic [79:0] ONE, TWO, PZERO, NZERO, PINF, NINF, QNAN, SNAN, PINF_BAD, UNNORM, DEN;

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cmp(input logic [79:0] a, input logic [79:0] b, input logic mode,
                      input logic mask, input logic uf, input logic [1:0] pr);
      @(negedge clk);
      op_a = a; op_b = b; unordered_mode = mode; inv_mask = mask;
      stk_underflow = uf; pop_req = pr; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; stk_underflow = 1'b0; pop_req = 2'd0;
   endtask

   task automatic t_reset;
      chk("R1 rsp_valid", {7'd0, rsp_valid}, 8'd0);
      chk("R1 cc", {5'd0, cc}, 8'd0);
      chk("R1 c1", {7'd0, c1}, 8'd0);
      chk("R1 flags", {5'd0, exc_invalid, exc_denormal, exc_stack}, 8'd0);
      chk("R1 pop", {6'd0, pop_cnt}, 8'd0);
   endtask

   task automatic t_relations;
      cmp(ONE, TWO, 0, 0, 0, 0);   chk("R3 1<2", {5'd0, cc}, 8'b001);
      chk("R2 valid", {7'd0, rsp_valid}, 8'd1);
      chk("R3 no invalid", {7'd0, exc_invalid}, 8'd0);
      chk("R8 c1 set", {7'd0, c1}, 8'd1);
      cmp(TWO, ONE, 0, 0, 0, 0);   chk("R3 2>1", {5'd0, cc}, 8'b000);
      cmp(ONE, ONE, 0, 0, 0, 0);   chk("R3 1=1", {5'd0, cc}, 8'b100);
      cmp(ONE ^ 80'h1, ONE, 0, 0, 0, 0); chk("R3 lsb gt", {5'd0, cc}, 8'b000);
      cmp({1'b1, ONE[78:0]}, ONE, 0, 0, 0, 0); chk("R3 -1<1", {5'd0, cc}, 8'b001);
      cmp({1'b1, TWO[78:0]}, {1'b1, ONE[78:0]}, 0, 0, 0, 0); chk("R3 -2<-1", {5'd0, cc}, 8'b001);
      cmp(PZERO, NZERO, 0, 0, 0, 0); chk("R3 +0=-0", {5'd0, cc}, 8'b100);
      cmp(PINF, PINF, 1, 0, 0, 0);   chk("R3 inf=inf", {5'd0, cc}, 8'b100);
      cmp(NINF, ONE, 0, 0, 0, 0);    chk("R3 -inf<1", {5'd0, cc}, 8'b001);
      cmp(NZERO, ONE, 0, 0, 0, 0);   chk("R3 -0<1", {5'd0, cc}, 8'b001);
      @(negedge clk);
      chk("R2 single pulse", {7'd0, rsp_valid}, 8'd0);
   endtask

   task automatic t_unordered;
      cmp(QNAN, ONE, 1, 0, 0, 0);
      chk("R4 qnan cc", {5'd0, cc}, 8'b111);
      chk("R4 qnan no invalid", {7'd0, exc_invalid}, 8'd0);
      cmp(ONE, TWO, 1, 0, 0, 0);
      cmp(SNAN, ONE, 1, 0, 0, 0);
      chk("R5 snan invalid", {7'd0, exc_invalid}, 8'd1);
      chk("R5 snan unmasked held", {5'd0, cc}, 8'b001);
      cmp(ONE, SNAN, 1, 1, 0, 0);
      chk("R5 snan masked cc", {5'd0, cc}, 8'b111);
      cmp(TWO, ONE, 1, 0, 0, 0);
      cmp(UNNORM, ONE, 1, 0, 0, 0);
      chk("R10 unnormal invalid", {7'd0, exc_invalid}, 8'd1);
      chk("R5 unnormal held", {5'd0, cc}, 8'b000);
      cmp(ONE, PINF_BAD, 1, 1, 0, 0);
      chk("R10 pseudo-inf invalid", {7'd0, exc_invalid}, 8'd1);
      chk("R5 pseudo-inf masked", {5'd0, cc}, 8'b111);
   endtask

   task automatic t_ordered;
      cmp(ONE, ONE, 0, 0, 0, 0);
      cmp(QNAN, ONE, 0, 0, 0, 0);
      chk("R6 qnan invalid", {7'd0, exc_invalid}, 8'd1);
      chk("R6 qnan unmasked held", {5'd0, cc}, 8'b100);
      cmp(ONE, QNAN, 0, 1, 0, 0);
      chk("R6 qnan masked", {5'd0, cc}, 8'b111);
   endtask

   task automatic t_denormal;
      cmp(DEN, PZERO, 0, 0, 0, 0);
      chk("R7 denormal flag", {7'd0, exc_denormal}, 8'd1);
      chk("R7 denormal order", {5'd0, cc}, 8'b000);
      chk("R7 no invalid", {7'd0, exc_invalid}, 8'd0);
      cmp(ONE, TWO, 0, 0, 0, 0);
      chk("R7 no denormal", {7'd0, exc_denormal}, 8'd0);
   endtask

   task automatic t_underflow;
      cmp(ONE, TWO, 0, 0, 0, 0);
      cmp(ONE, ONE, 0, 0, 1, 0);
      chk("R8 stack flags", {5'd0, exc_stack, exc_invalid, c1}, 8'b110);
      chk("R8 unmasked held", {5'd0, cc}, 8'b001);
      cmp(DEN, ONE, 0, 1, 1, 0);
      chk("R8 masked cc", {5'd0, cc}, 8'b111);
      chk("R8 denormal suppressed", {7'd0, exc_denormal}, 8'd0);
   endtask

   task automatic t_pops;
      for (int p = 0; p < 4; p++) begin
         cmp(ONE, TWO, 0, 0, 0, 2'(p));
         chk("R9 pop count", {6'd0, pop_cnt}, (p == 3) ? 8'd2 : 8'(p));
      end
      @(negedge clk);
      chk("R9 idle pop", {6'd0, pop_cnt}, 8'd0);
   endtask

   initial begin
      ONE      = mk(0, 15'h3FFF, INTB);
      TWO      = mk(0, 15'h4000, INTB);
      PZERO    = mk(0, 15'h0, 64'h0);
      NZERO    = mk(1, 15'h0, 64'h0);
      PINF     = mk(0, 15'h7FFF, INTB);
      NINF     = mk(1, 15'h7FFF, INTB);
      QNAN     = mk(0, 15'h7FFF, 64'hC000_0000_0000_0000);
      SNAN     = mk(0, 15'h7FFF, 64'hA000_0000_0000_0000);
      PINF_BAD = mk(0, 15'h7FFF, 64'h0);
      UNNORM   = mk(0, 15'h3FFF, 64'h4000_0000_0000_0000);
      DEN      = mk(0, 15'h0, 64'h1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_relations();
      t_unordered();
      t_ordered();
      t_denormal();
      t_underflow();
      t_pops();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule